// File: doc/BRIEF.md
# Sampling ADC Conversion Sequencer

This block paces an external 14-bit two-pass sampling converter and collects its results. It runs from a 100 MHz clock. Each sample period is a programmed number of cycles. At the start of each period the block raises the start-convert line for a programmed number of cycles. Any high time whose falling edge would land in the converter's forbidden window falls back to a safe 20 ns pulse. The converter's end-of-conversion line is brought into the clock domain through a synchroniser. A programmable number of cycles after that line falls, the parallel result word is captured, turned from offset binary into two's complement, and presented with a one-cycle valid strobe.

Starting a new conversion while the converter still reports busy corrupts two results. The block does not try to avoid this. It records the event in a sticky error flag and discards both affected results. A warm-up mode keeps the start pulses running so the converter stays exercised, and throws every result away. A busy output tells surrounding logic whether a conversion is still outstanding.

Top module: `adc_seq_top`

## Requirements
- R1: Start-convert rises once per sample period, and consecutive rises are exactly `period_cyc` cycles apart; any value below 34 is treated as 34.
- R2: The start pulse stays high for `high_cyc` cycles when that value is legal, and for 2 cycles otherwise. Legal values are 1 to 11, 16 to 30, or above 30 when the effective period exceeds 34 and leaves at least 3 low cycles.
- R3: Period and high time are sampled once, in the cycle that begins a period. A change made during a pulse first shows on the following pulse.
- R4: While neither `run_en` nor `warmup_en` is set, start-convert stays low once the period in progress has ended. Setting `run_en` in an idle state raises start-convert on the very next clock edge.
- R5: The end-of-conversion input passes through two synchroniser flops. `smp_valid` rises on the (4 + `cap_dly`)-th rising clock edge after the input falls.
- R6: `smp_data` equals the captured word with its top bit (bit 13) inverted, read as signed. Code 0x3FFF gives 8191, 0x2000 gives 0, 0x0000 gives -8192 and 0x1FFF gives -1.
- R7: `smp_valid` is a single-cycle pulse, and `smp_data` holds its value until the next accepted capture.
- R8: With `warmup_en` set, start pulses keep running but no valid strobe is raised and `smp_data` does not change.
- R9: A period that begins while the synchronised end-of-conversion is high sets `proto_err`, which stays set until it is cleared.
- R10: After such a restart, any capture waiting from the interrupted conversion is cancelled and the next end-of-conversion fall is ignored. The first conversion that starts cleanly afterwards is captured normally.
- R11: A one-cycle pulse on `err_clr` clears `proto_err` on the next clock edge.
- R12: `busy` rises on the clock edge that raises start-convert. It falls on the edge that delivers that conversion's result or discards it.
- R13: After reset, start-convert, `smp_valid`, `proto_err` and `busy` are low and `smp_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Convert and deliver samples |
| warmup_en | input | 1 | Keep converting, discard results |
| period_cyc | input | 16 | Sample period in clock cycles (minimum 34) |
| high_cyc | input | 16 | Start pulse high time in clock cycles |
| cap_dly | input | 4 | Extra cycles between detected EOC fall and data capture |
| err_clr | input | 1 | Pulse to clear the sticky protocol error |
| conv_start | output | 1 | Start-convert to the converter |
| conv_eoc | input | 1 | End-of-conversion status from the converter (asynchronous) |
| conv_data | input | 14 | Parallel offset-binary result from the converter |
| smp_data | output | 14 | Signed two's-complement sample |
| smp_valid | output | 1 | One-cycle strobe marking a new sample |
| proto_err | output | 1 | Sticky flag: a start was issued while the converter was busy |
| busy | output | 1 | A conversion is outstanding |

## Verification
The bench sweeps high-time settings on both sides of the forbidden window (11 and 16 against 13, 30 against 31) and at the low-time limit for long pulses. A wrong legality check shows up directly as a pulse that falls inside the dead band or leaves too little low time. It changes settings in the middle of a pulse to catch a design that lets one pulse take on a new width partway through. It measures capture latency at three delay settings and checks the sign conversion at full scale, zero and both sides of zero. Off-by-one pipelining or a swapped bit would show up as a wrong count or value. A slow behavioural converter forces restarts during busy. A design that delivers the merged result, keeps a stale capture or fails to recover on the next clean conversion is caught, and so is a design that lets warm-up results leak out.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the conversion sequencer.
// Assumes a converter that presents offset-binary codes of ADC_BITS bits.
package adc_seq_pkg;
    localparam int unsigned ADC_BITS = 14;

    typedef logic        [ADC_BITS-1:0] adc_word_t;
    typedef logic signed [ADC_BITS-1:0] adc_sample_t;

    // Offset binary to two's complement: flip the sign bit, keep the rest.
    function automatic adc_sample_t ob_to_tc(input adc_word_t code);
        adc_word_t flipped;
        flipped = code;
        flipped[ADC_BITS-1] = ~code[ADC_BITS-1];
        return $signed(flipped);
    endfunction
endpackage

// File: rtl/adc_seq_pulse_gen.sv
`timescale 1ns/1ps
// Start-convert pulse generator.
// Counts a sample period in clock cycles and drives the start line high for
// a legalised number of cycles at the beginning of each period. Settings are
// sampled once per period. Once a period has begun it always runs to its
// end, so a stop request cannot truncate a pulse into the forbidden window.
// Assumes a clock period equal to one unit of the window parameters (10 ns).
module adc_seq_pulse_gen #(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned MIN_PERIOD  = 34,
    parameter int unsigned WIN_A_MAX   = 11,
    parameter int unsigned WIN_B_MIN   = 16,
    parameter int unsigned WIN_B_MAX   = 30,
    parameter int unsigned MIN_LOW     = 3,
    parameter int unsigned HI_FALLBACK = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] high_i,
    output logic             start_o,
    output logic             issue_o
);
    localparam logic [CNT_W-1:0] P_MIN   = CNT_W'(MIN_PERIOD);
    localparam logic [CNT_W-1:0] P_AMAX  = CNT_W'(WIN_A_MAX);
    localparam logic [CNT_W-1:0] P_BMIN  = CNT_W'(WIN_B_MIN);
    localparam logic [CNT_W-1:0] P_BMAX  = CNT_W'(WIN_B_MAX);
    localparam logic [CNT_W-1:0] P_LOW   = CNT_W'(MIN_LOW);
    localparam logic [CNT_W-1:0] P_FALL  = CNT_W'(HI_FALLBACK);
    localparam logic [CNT_W-1:0] P_ONE   = CNT_W'(1);

    logic [CNT_W-1:0] per_eff, hi_eff;
    logic             hi_ok;
    logic [CNT_W-1:0] phase_q, per_q, hi_q;
    logic             start_q;

    // Clamp the period and check the requested high time against the windows.
    always_comb begin
        per_eff = (period_i < P_MIN) ? P_MIN : period_i;
        hi_ok   = ((high_i >= P_ONE) && (high_i <= P_AMAX)) ||
                  ((high_i >= P_BMIN) && (high_i <= P_BMAX)) ||
                  ((high_i > P_BMAX) && (per_eff > P_MIN) &&
                   (high_i <= per_eff - P_LOW));
        hi_eff  = hi_ok ? high_i : P_FALL;
    end

    assign issue_o = active_i && (phase_q == '0);
    assign start_o = start_q;

    // Period phase counter and start-line register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            per_q   <= P_MIN;
            hi_q    <= P_FALL;
            start_q <= 1'b0;
        end else if (phase_q == '0) begin
            if (active_i) begin
                per_q   <= per_eff;
                hi_q    <= hi_eff;
                start_q <= 1'b1;
                phase_q <= P_ONE;
            end else begin
                start_q <= 1'b0;
            end
        end else begin
            start_q <= (phase_q < hi_q);
            phase_q <= (phase_q == per_q - P_ONE) ? '0 : phase_q + P_ONE;
        end
    end

    // ---- protocol watch counters (feed the assertions only) ----
    logic             start_d;
    logic [CNT_W-1:0] hi_run, lo_run, gap_run;

    // Track run lengths of the start line and the rise-to-rise gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_d <= 1'b0;
            hi_run  <= '0;
            lo_run  <= '1;
            gap_run <= '1;
        end else begin
            start_d <= start_q;
            hi_run  <= start_q ? ((hi_run == '1) ? hi_run : hi_run + P_ONE) : '0;
            lo_run  <= start_q ? '0 : ((lo_run == '1) ? lo_run : lo_run + P_ONE);
            gap_run <= (start_q && !start_d) ? P_ONE
                     : ((gap_run == '1) ? gap_run : gap_run + P_ONE);
        end
    end

    // R2
    no_deadband_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_d && !start_q) |-> ((hi_run != '0) && !((hi_run > P_AMAX) && (hi_run < P_BMIN))))
        else $error("start pulse fell inside the forbidden window");

    // R2
    min_low_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_q && !start_d) |-> (lo_run >= P_LOW))
        else $error("start line low time too short");

    // R1
    min_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_q && !start_d) |-> (gap_run >= P_MIN))
        else $error("start pulses closer than the minimum period");
endmodule

// File: rtl/adc_seq_eoc_sync.sv
`timescale 1ns/1ps
// End-of-conversion synchroniser and falling-edge detector.
// Assumes the input is asynchronous to clk; STAGES flops settle it, and one
// more flop provides the previous value for edge detection.
module adc_seq_eoc_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic eoc_i,
    output logic eoc_s_o,
    output logic eoc_fall_o
);
    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            logic q;
            if (g == 0) begin : g_first
                // First synchroniser flop samples the raw input.
                always_ff @(posedge clk) begin
                    if (!rst_n) q <= 1'b0;
                    else        q <= eoc_i;
                end
            end else begin : g_next
                // Later flops extend the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) q <= 1'b0;
                    else        q <= g_stage[g-1].q;
                end
            end
        end
    endgenerate

    logic prev_q;

    // Hold the previous synchronised value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= g_stage[STAGES-1].q;
    end

    assign eoc_s_o    = g_stage[STAGES-1].q;
    assign eoc_fall_o = prev_q && !g_stage[STAGES-1].q;

    // R5
    fall_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_fall_o |=> !eoc_fall_o)
        else $error("EOC fall indication longer than one cycle");
endmodule

// File: rtl/adc_seq_capture.sv
`timescale 1ns/1ps
// Result capture, restart detection and busy tracking.
// Captures the data bus cap_dly_i cycles after a detected EOC fall, converts
// it to two's complement and strobes it out. A period that begins while the
// synchronised EOC is high is a protocol violation: the pending capture is
// cancelled and the next EOC fall is discarded.
module adc_seq_capture
    import adc_seq_pkg::*;
#(
    parameter int unsigned DLY_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      issue_i,
    input  logic                      eoc_s_i,
    input  logic                      eoc_fall_i,
    input  logic                      warmup_i,
    input  logic                      err_clr_i,
    input  logic [DLY_W-1:0]          cap_dly_i,
    input  adc_word_t                 data_i,
    output adc_sample_t               smp_data_o,
    output logic                      smp_valid_o,
    output logic                      proto_err_o,
    output logic                      busy_o
);
    logic             viol, fire, drop;
    logic             pend_q, skip_q;
    logic [DLY_W-1:0] dcnt_q;
    adc_sample_t      data_q;
    logic             valid_q, err_q, busy_q;

    assign viol = issue_i && eoc_s_i;
    assign fire = pend_q && (dcnt_q == '0) && !viol;
    assign drop = eoc_fall_i && skip_q && !viol;

    // Capture scheduling: arm on EOC fall, count down, cancel on violation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            skip_q <= 1'b0;
            dcnt_q <= '0;
        end else if (viol) begin
            pend_q <= 1'b0;
            skip_q <= 1'b1;
        end else if (eoc_fall_i) begin
            if (skip_q) begin
                skip_q <= 1'b0;
            end else begin
                pend_q <= 1'b1;
                dcnt_q <= cap_dly_i;
            end
        end else if (pend_q) begin
            if (dcnt_q == '0) pend_q <= 1'b0;
            else              dcnt_q <= dcnt_q - 1'b1;
        end
    end

    // Output register: latch and convert the word unless warming up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= fire && !warmup_i;
            if (fire && !warmup_i) data_q <= ob_to_tc(data_i);
        end
    end

    // Sticky protocol error, set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         err_q <= 1'b0;
        else if (viol)      err_q <= 1'b1;
        else if (err_clr_i) err_q <= 1'b0;
    end

    // Busy from issue until the result is delivered or discarded.
    always_ff @(posedge clk) begin
        if (!rst_n)            busy_q <= 1'b0;
        else if (issue_i)      busy_q <= 1'b1;
        else if (fire || drop) busy_q <= 1'b0;
    end

    assign smp_data_o  = data_q;
    assign smp_valid_o = valid_q;
    assign proto_err_o = err_q;
    assign busy_o      = busy_q;

    // R9
    err_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> proto_err_o)
        else $error("violation did not set the error flag");

    // R11
    err_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr_i && !viol) |=> !proto_err_o)
        else $error("error flag not cleared");

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid_o |=> !smp_valid_o)
        else $error("valid strobe longer than one cycle");

    // R8
    warmup_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warmup_i |=> !smp_valid_o)
        else $error("valid strobe during warm-up");

    // R7
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid_o |-> $stable(smp_data_o))
        else $error("sample changed without a strobe");
endmodule

// File: rtl/adc_seq_top.sv
`timescale 1ns/1ps
// Conversion sequencer top: pulse generator, EOC synchroniser and capture.
// Assumes a 100 MHz clock and an asynchronous end-of-conversion input.
module adc_seq_top
    import adc_seq_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned DLY_W       = 4,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned MIN_PERIOD  = 34,
    parameter int unsigned HI_FALLBACK = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       run_en,
    input  logic                       warmup_en,
    input  logic [CNT_W-1:0]           period_cyc,
    input  logic [CNT_W-1:0]           high_cyc,
    input  logic [DLY_W-1:0]           cap_dly,
    input  logic                       err_clr,
    output logic                       conv_start,
    input  logic                       conv_eoc,
    input  logic [ADC_BITS-1:0]        conv_data,
    output logic signed [ADC_BITS-1:0] smp_data,
    output logic                       smp_valid,
    output logic                       proto_err,
    output logic                       busy
);
    logic issue, eoc_s, eoc_fall;

    adc_seq_pulse_gen #(
        .CNT_W      (CNT_W),
        .MIN_PERIOD (MIN_PERIOD),
        .WIN_A_MAX  (11),
        .WIN_B_MIN  (16),
        .WIN_B_MAX  (30),
        .MIN_LOW    (3),
        .HI_FALLBACK(HI_FALLBACK)
    ) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .active_i(run_en || warmup_en),
        .period_i(period_cyc),
        .high_i  (high_cyc),
        .start_o (conv_start),
        .issue_o (issue)
    );

    adc_seq_eoc_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .eoc_i     (conv_eoc),
        .eoc_s_o   (eoc_s),
        .eoc_fall_o(eoc_fall)
    );

    adc_seq_capture #(
        .DLY_W(DLY_W)
    ) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_i    (issue),
        .eoc_s_i    (eoc_s),
        .eoc_fall_i (eoc_fall),
        .warmup_i   (warmup_en),
        .err_clr_i  (err_clr),
        .cap_dly_i  (cap_dly),
        .data_i     (conv_data),
        .smp_data_o (smp_data),
        .smp_valid_o(smp_valid),
        .proto_err_o(proto_err),
        .busy_o     (busy)
    );
endmodule

// File: tb/adc_seq_top_bench.sv
`timescale 1ns/1ps
module adc_seq_top_bench;
    localparam int CLK_NS       = 10;
    localparam int WATCHDOG_CYC = 150000;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               run_en = 1'b0, warmup_en = 1'b0, err_clr = 1'b0;
    logic [15:0]        period_cyc = 16'd34, high_cyc = 16'd2;
    logic [3:0]         cap_dly = 4'd2;
    logic               conv_start;
    logic               conv_eoc = 1'b0;
    logic [13:0]        conv_data = 14'h0000;
    logic signed [13:0] smp_data;
    logic               smp_valid, proto_err, busy;

    int checks = 0, failures = 0;
    int vcount = 0;
    bit done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    adc_seq_top u_adc_seq_top (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .warmup_en(warmup_en),
        .period_cyc(period_cyc), .high_cyc(high_cyc), .cap_dly(cap_dly),
        .err_clr(err_clr), .conv_start(conv_start), .conv_eoc(conv_eoc),
        .conv_data(conv_data), .smp_data(smp_data), .smp_valid(smp_valid),
        .proto_err(proto_err), .busy(busy)
    );

    // Behavioural converter: EOC up shortly after the start edge, down after
    // the conversion time; a new start while busy restarts the conversion.
    int          rise_ns = 12;
    int          conv_ns = 124;
    int unsigned gen_q = 0;
    logic [13:0] next_code = 14'h2000;

    always @(posedge conv_start) begin
        gen_q = gen_q + 1;
        fork
            begin
                automatic int unsigned my_gen = gen_q;
                #(rise_ns) conv_eoc = 1'b1;
                #(conv_ns);
                if (my_gen == gen_q) begin
                    conv_eoc  = 1'b0;
                    conv_data = 14'h1555;
                    #4 conv_data = next_code;
                end
            end
        join_none
    end

    // Count valid strobes away from the active edge.
    always @(negedge clk) if (smp_valid) vcount = vcount + 1;

    task automatic check_eq(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG_CYC, 0);
        finish_run();
    end

    task automatic go_idle();
        @(negedge clk);
        run_en = 1'b0;
        warmup_en = 1'b0;
        repeat (80) @(negedge clk);
    endtask

    // Measure one pulse: high cycles and rise-to-rise distance.
    task automatic measure(output int w, output int p);
        while (conv_start) @(negedge clk);
        while (!conv_start) @(negedge clk);
        w = 0;
        while (conv_start) begin w++; @(negedge clk); end
        p = w;
        while (!conv_start) begin p++; @(negedge clk); end
    endtask

    task automatic t_reset();
        check_eq("R13", "start after reset", conv_start, 0);
        check_eq("R13", "valid after reset", smp_valid, 0);
        check_eq("R13", "error after reset", proto_err, 0);
        check_eq("R13", "busy after reset", busy, 0);
        check_eq("R13", "data after reset", smp_data, 0);
    endtask

    task automatic t_widths();
        int per_t [11] = '{40, 20, 34, 34, 34, 34, 34, 50, 50, 50, 40};
        int hi_t  [11] = '{ 5,  3, 13, 11, 16, 30, 31, 31, 48, 47,  0};
        int ew_t  [11] = '{ 5,  3,  2, 11, 16, 30,  2, 31,  2, 47,  2};
        int ep_t  [11] = '{40, 34, 34, 34, 34, 34, 34, 50, 50, 50, 40};
        for (int i = 0; i < 11; i++) begin
            int w, p;
            go_idle();
            period_cyc = 16'(per_t[i]);
            high_cyc   = 16'(hi_t[i]);
            run_en     = 1'b1;
            measure(w, p);
            check_eq("R2", $sformatf("high time for setting %0d/%0d", per_t[i], hi_t[i]), w, ew_t[i]);
            check_eq("R1", $sformatf("period for setting %0d/%0d", per_t[i], hi_t[i]), p, ep_t[i]);
        end
    endtask

    task automatic t_latch();
        int w, p, rem;
        go_idle();
        period_cyc = 16'd40;
        high_cyc   = 16'd5;
        run_en     = 1'b1;
        measure(w, p);
        high_cyc = 16'd8;
        rem = 0;
        while (conv_start) begin rem++; @(negedge clk); end
        check_eq("R3", "pulse in progress keeps old width", rem, 5);
        measure(w, p);
        check_eq("R3", "next pulse takes new width", w, 8);
    endtask

    task automatic t_inactive();
        int highs = 0;
        go_idle();
        for (int i = 0; i < 100; i++) begin
            if (conv_start) highs++;
            @(negedge clk);
        end
        check_eq("R4", "start cycles while idle", highs, 0);
        run_en = 1'b1;
        @(negedge clk);
        check_eq("R4", "start on first edge after enable", conv_start, 1);
    endtask

    task automatic capture_one(input logic [13:0] code, input int exp_val, input int dly);
        int k = 0;
        logic signed [13:0] held;
        next_code = code;
        cap_dly = 4'(dly);
        @(posedge conv_start);
        #1;
        check_eq("R12", "busy at start", busy, 1);
        @(negedge conv_eoc);
        do begin @(posedge clk); #1; k++; end while (!smp_valid && k < 40);
        check_eq("R5", $sformatf("capture latency delay=%0d", dly), k, 4 + dly);
        check_eq("R6", $sformatf("sample for code %h", code), smp_data, exp_val);
        check_eq("R12", "busy after result", busy, 0);
        held = smp_data;
        @(posedge clk);
        #1;
        check_eq("R7", "valid lasts one cycle", smp_valid, 0);
        check_eq("R7", "data held after strobe", smp_data, held);
    endtask

    task automatic t_capture();
        go_idle();
        period_cyc = 16'd34;
        high_cyc   = 16'd2;
        run_en     = 1'b1;
        capture_one(14'h3FFF,  8191, 2);
        capture_one(14'h2000,     0, 2);
        capture_one(14'h0000, -8192, 2);
        capture_one(14'h1FFF,    -1, 5);
        capture_one(14'h2001,     1, 0);
        capture_one(14'h2AAA,  2730, 2);
    endtask

    task automatic t_warmup();
        int rises = 0, v0;
        logic prev = 1'b0;
        logic signed [13:0] d0;
        go_idle();
        d0 = smp_data;
        v0 = vcount;
        warmup_en = 1'b1;
        for (int i = 0; i < 340; i++) begin
            @(negedge clk);
            if (conv_start && !prev) rises++;
            prev = conv_start;
        end
        @(posedge clk);
        #1;
        check_eq("R8", "warm-up keeps pulsing (>=9)", rises >= 9, 1);
        check_eq("R8", "no strobes in warm-up", vcount - v0, 0);
        check_eq("R8", "data unchanged in warm-up", smp_data, d0);
    endtask

    task automatic t_violation();
        int v0, k = 0;
        go_idle();
        conv_ns    = 500;
        period_cyc = 16'd34;
        high_cyc   = 16'd2;
        @(posedge clk);
        #1;
        v0 = vcount;
        @(negedge clk);
        run_en = 1'b1;
        repeat (3) @(posedge conv_start);
        @(negedge clk);
        run_en = 1'b0;
        repeat (120) @(negedge clk);
        @(posedge clk);
        #1;
        check_eq("R9", "error after restart while busy", proto_err, 1);
        check_eq("R10", "corrupted results discarded", vcount - v0, 0);
        check_eq("R12", "busy cleared after discard", busy, 0);
        conv_ns   = 124;
        next_code = 14'h2123;
        @(negedge clk);
        run_en = 1'b1;
        do begin @(posedge clk); #1; k++; end while (!smp_valid && k < 200);
        check_eq("R10", "clean conversion captured after restart", smp_data, 291);
        go_idle();
        check_eq("R9", "error stays set", proto_err, 1);
    endtask

    task automatic t_errclr();
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        check_eq("R11", "error cleared by pulse", proto_err, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_widths();
        t_latch();
        t_inactive();
        t_capture();
        t_warmup();
        t_violation();
        t_errclr();
        go_idle();
        finish_run();
    end
endmodule